// File: doc/BRIEF.md
# Carrier Interrupt Control and Status

This block is the interrupt register file of a carrier board that hosts four plug-in modules. Each module drives two active-low interrupt request lines and one timeout strobe. Software reaches the block over a small 16-bit register bus. The bus holds one 8-bit control word per module and one 16-bit status word shared by all modules.

Each request line is gated by an enable bit in its module's control word. While enabled, the line's state is copied into a status bit. Each line is also configured as edge or level sensitive. An edge line that newly sets its status bit gives the host a one-cycle pulse. Level lines hold the host line high for as long as any of their status bits is set. All sources are merged onto one host interrupt output.

Interrupt status bits cannot be cleared by software. Writing a one to such a bit sends an acknowledge strobe to the module, which is then expected to release its line. Timeout flags are set by the per-module strobes and cleared by writing ones to them.

All inputs are taken as synchronous to the block clock. The block has no bus bridge and no timeout detection.

Top module: `irq_carrier_regs`

## Requirements
- R1: After synchronous reset (rst_n low on a clock edge), all control words, all status bits, `host_irq` and `slot_ack` are zero.
- R2: Register access uses word offsets and gives its result one cycle late. A read strobe on one cycle places the read value on `bus_rdata` after the next clock edge, and `bus_rdata` is zero when there was no read. The word offsets are:
  - 0 is the revision word: it reads zero and writes to it are ignored.
  - 1 to 4 are the control words of modules 0 to 3 (module = offset − 1). They are read back zero-extended.
  - 5 is a reset word: it reads zero and writes to it have no effect.
  - 6 is the status word.
  - Offsets 7 to 15 read zero.
- R3: In the control word of module m, bit 6+n enables request line n and bit 4+n makes it edge sensitive (clear means level sensitive). Bits 0 to 3 are stored and read back only.
- R4: Status bit 2m+n follows request line n of module m while that line is enabled. The bit is 1 when the line is low, and it is updated on the clock edge that samples the line.
- R5: While a line's enable bit is clear, changes on that line are ignored and its status bit keeps its value.
- R6: For an edge-sensitive line, a 0-to-1 change of its status bit drives `host_irq` high for exactly one cycle, on the same edge. The status bit returning to 0 produces no pulse.
- R7: `host_irq` is high while any status interrupt bit of a level-sensitive line is set. It is low when no such bit is set and no edge pulse is due. Status bits of edge-sensitive lines never hold it high.
- R8: A strobe on `slot_timeout[m]` sets status bit 12+m. Writing 1 to that bit clears it. A strobe and a clearing write in the same cycle leave the bit set.
- R9: Writing 1 to status bit 2m+n pulses `slot_ack[2m+n]` high for one cycle. It does not change the status bit directly.
- R10: Status bits 8 to 11 (error flags) always read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_offs | input | 4 | Word offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| slot_irq_n | input | 8 | Active-low request lines, index 2·module + line |
| slot_timeout | input | 4 | Per-module timeout strobes |
| slot_ack | output | 8 | One-cycle acknowledge strobes toward the modules |
| host_irq | output | 1 | Merged host interrupt |

## Verification
The hardest cases to reach are a status bit that is frozen with its line disabled and an edge pulse caused by enabling a line that is already asserted. The bench sets up the first by asserting a level line while it is enabled, then clearing the enable and toggling the line. It then checks that the status bit and `host_irq` still hold. For the second, it asserts a line while the line is disabled, then writes an edge-sensitive, enabled control word. It expects a single pulse one edge after that write. The bench also sweeps every line through all four enable/edge combinations.

// File: rtl/irq_carrier_pkg.sv
// Shared constants of the carrier interrupt register block.
// Assumes two request lines per module and an 8-bit control word.
package irq_carrier_pkg;
    localparam int unsigned LINES_PER_SLOT = 2;
    localparam int unsigned CTL_W          = 8;
    // control word field positions (decoded by the line logic)
    localparam int unsigned CB_EDGE_BASE   = 4;
    localparam int unsigned CB_EN_BASE     = 6;
    // fixed word offsets
    localparam int unsigned OFF_REV        = 0;
    localparam int unsigned OFF_CTL_BASE   = 1;

    typedef struct packed {
        logic rev;
        logic rst;
        logic stat;
    } fixed_hit_t;
endpackage

// File: rtl/irq_carrier_decode.sv
// Offset decoder: turns a word offset into one-hot hits for the
// control words and the fixed registers. Does not qualify with the strobe.
module irq_carrier_decode
    import irq_carrier_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned OFFS_W    = 4
) (
    input  logic [OFFS_W-1:0]    offs,
    output logic [NUM_SLOTS-1:0] ctl_hit,
    output fixed_hit_t           fix_hit
);
    localparam int unsigned OFF_RST  = OFF_CTL_BASE + NUM_SLOTS;
    localparam int unsigned OFF_STAT = OFF_RST + 1;

    // one control hit per module
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ctl
        assign ctl_hit[s] = (offs == OFFS_W'(OFF_CTL_BASE + s));
    end

    // fixed register hits
    always_comb begin
        fix_hit.rev  = (offs == OFFS_W'(OFF_REV));
        fix_hit.rst  = (offs == OFFS_W'(OFF_RST));
        fix_hit.stat = (offs == OFFS_W'(OFF_STAT));
    end
endmodule

// File: rtl/irq_carrier_ctl_bank.sv
// Bank of per-module control words. A word loads when its select bit
// is set; selects are expected one-hot and already qualified by a write.
module irq_carrier_ctl_bank
    import irq_carrier_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SLOTS-1:0]              wr_sel,
    input  logic [CTL_W-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][CTL_W-1:0]   ctl_q
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_word
        // hold or load one control word
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_q[s] <= '0;
            else if (wr_sel[s])
                ctl_q[s] <= wr_data;
        end
    end
endmodule

// File: rtl/irq_carrier_line.sv
// One request line: gates the active-low request with its enable bit,
// keeps the status bit and flags a status rise on an edge-sensitive line.
// Assumes req_n is synchronous to clk.
module irq_carrier_line (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic enable,
    input  logic edge_sel,
    output logic stat_q,
    output logic stat_next,
    output logic rise_next
);
    // next status: track the line only while enabled
    always_comb begin
        stat_next = enable ? ~req_n : stat_q;
        rise_next = enable & edge_sel & ~stat_q & ~req_n;
    end

    // status bit register
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= 1'b0;
        else
            stat_q <= stat_next;
    end
endmodule

// File: rtl/irq_carrier_tmo.sv
// Timeout flags: set by strobes, cleared by write-one, set wins.
module irq_carrier_tmo #(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] set_in,
    input  logic [NUM_SLOTS-1:0] clr_in,
    output logic [NUM_SLOTS-1:0] flags_q
);
    // update flags, a set beats a clear on the same bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~clr_in) | set_in;
    end
endmodule

// File: rtl/irq_carrier_regs.sv
// Carrier interrupt control and status block (top).
// Holds per-module control words and the shared status word, merges
// edge and level sources onto one registered host interrupt.
// Assumes all inputs are synchronous to clk and 4*NUM_SLOTS <= DATA_W.
module irq_carrier_regs
    import irq_carrier_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned OFFS_W    = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_valid,
    input  logic                                 bus_write,
    input  logic [OFFS_W-1:0]                    bus_offs,
    input  logic [DATA_W-1:0]                    bus_wdata,
    output logic [DATA_W-1:0]                    bus_rdata,
    input  logic [NUM_SLOTS*LINES_PER_SLOT-1:0]  slot_irq_n,
    input  logic [NUM_SLOTS-1:0]                 slot_timeout,
    output logic [NUM_SLOTS*LINES_PER_SLOT-1:0]  slot_ack,
    output logic                                 host_irq
);
    localparam int unsigned NL       = NUM_SLOTS * LINES_PER_SLOT;
    localparam int unsigned ERR_BASE = NL;
    localparam int unsigned TMO_BASE = NL + NUM_SLOTS;
    localparam int unsigned STAT_W   = NL + 2 * NUM_SLOTS;

    logic [NUM_SLOTS-1:0]            ctl_hit;
    fixed_hit_t                      fix_hit;
    logic [NUM_SLOTS-1:0]            ctl_wr;
    logic                            stat_wr;
    logic                            rd_en;
    logic [NUM_SLOTS-1:0][CTL_W-1:0] ctl_q;
    logic [NL-1:0]                   en_mask;
    logic [NL-1:0]                   edge_mask;
    logic [NL-1:0]                   stat_int_q;
    logic [NL-1:0]                   stat_int_d;
    logic [NL-1:0]                   rise_d;
    logic [NUM_SLOTS-1:0]            tmo_q;
    logic [STAT_W-1:0]               status_word;
    logic [DATA_W-1:0]               rd_mux;
    logic [DATA_W-1:0]               rdata_q;
    logic [NL-1:0]                   ack_q;
    logic                            host_q;
    logic                            unused_wdata;

    // offset decode
    irq_carrier_decode #(.NUM_SLOTS(NUM_SLOTS), .OFFS_W(OFFS_W)) u_dec (
        .offs    (bus_offs),
        .ctl_hit (ctl_hit),
        .fix_hit (fix_hit)
    );

    // qualify decode with the bus strobe
    always_comb begin
        ctl_wr  = {NUM_SLOTS{bus_valid & bus_write}} & ctl_hit;
        stat_wr = bus_valid & bus_write & fix_hit.stat;
        rd_en   = bus_valid & ~bus_write;
    end

    // control words
    irq_carrier_ctl_bank #(.NUM_SLOTS(NUM_SLOTS)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (ctl_wr),
        .wr_data (bus_wdata[CTL_W-1:0]),
        .ctl_q   (ctl_q)
    );

    // per-line enable/edge fields and line logic
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar n = 0; n < LINES_PER_SLOT; n++) begin : g_line
            localparam int unsigned IDX = s * LINES_PER_SLOT + n;
            assign en_mask[IDX]   = ctl_q[s][CB_EN_BASE + n];
            assign edge_mask[IDX] = ctl_q[s][CB_EDGE_BASE + n];
            irq_carrier_line u_line (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_n     (slot_irq_n[IDX]),
                .enable    (en_mask[IDX]),
                .edge_sel  (edge_mask[IDX]),
                .stat_q    (stat_int_q[IDX]),
                .stat_next (stat_int_d[IDX]),
                .rise_next (rise_d[IDX])
            );
        end
    end

    // timeout flags
    irq_carrier_tmo #(.NUM_SLOTS(NUM_SLOTS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_in  (slot_timeout),
        .clr_in  ({NUM_SLOTS{stat_wr}} & bus_wdata[TMO_BASE +: NUM_SLOTS]),
        .flags_q (tmo_q)
    );

    // error field of the write data has no destination
    assign unused_wdata = ^bus_wdata[ERR_BASE +: NUM_SLOTS]
                        ^ ^bus_wdata[DATA_W-1:CTL_W];

    // assemble status: timeouts, zero error flags, interrupt bits
    assign status_word = {tmo_q, {NUM_SLOTS{1'b0}}, stat_int_q};

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        if (fix_hit.stat)
            rd_mux = DATA_W'(status_word);
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (ctl_hit[s])
                rd_mux = DATA_W'(ctl_q[s]);
        end
    end

    // read data register, zero when no read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rd_en ? rd_mux : '0;
    end

    // acknowledge strobes toward the modules
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= '0;
        else
            ack_q <= stat_wr ? bus_wdata[NL-1:0] : '0;
    end

    // host output: level sources plus one-cycle edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_q <= 1'b0;
        else
            host_q <= (|(stat_int_d & ~edge_mask)) | (|rise_d);
    end

    assign bus_rdata = rdata_q;
    assign slot_ack  = ack_q;
    assign host_irq  = host_q;
endmodule

// File: rtl/irq_carrier_chk.sv
// Assertion checker for irq_carrier_regs, attached by bind.
module irq_carrier_chk #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned OFFS_W    = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [OFFS_W-1:0]      bus_offs,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [NUM_SLOTS-1:0]   slot_timeout,
    input logic [2*NUM_SLOTS-1:0] slot_ack,
    input logic                   host_irq,
    input logic [2*NUM_SLOTS-1:0] stat_int,
    input logic [2*NUM_SLOTS-1:0] en_mask,
    input logic [2*NUM_SLOTS-1:0] edge_mask,
    input logic [NUM_SLOTS-1:0]   tmo_flags
);
    localparam int unsigned NL       = 2 * NUM_SLOTS;
    localparam int unsigned OFF_STAT = NUM_SLOTS + 2;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!host_irq && slot_ack == '0 && stat_int == '0 && tmo_flags == '0));

    assert_rev_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && !bus_write && bus_offs == '0) |-> bus_rdata == '0);

    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && !bus_write && bus_offs == OFFS_W'(OFF_STAT))
        |-> bus_rdata[NL +: NUM_SLOTS] == '0);

    assert_ack_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_ack) |-> $past(bus_valid && bus_write && bus_offs == OFFS_W'(OFF_STAT)));

    assert_level_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_int & ~$past(edge_mask))) |-> host_irq);

    for (genvar i = 0; i < NL; i++) begin : g_line
        assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!en_mask[i]) |-> $stable(stat_int[i]));
        assert_edge_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(stat_int[i]) && $past(edge_mask[i])) |-> host_irq);
    end

    for (genvar m = 0; m < NUM_SLOTS; m++) begin : g_tmo
        assert_tmo_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            slot_timeout[m] |=> tmo_flags[m]);
    end
endmodule

bind irq_carrier_regs irq_carrier_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .OFFS_W    (OFFS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_offs     (bus_offs),
    .bus_rdata    (bus_rdata),
    .slot_timeout (slot_timeout),
    .slot_ack     (slot_ack),
    .host_irq     (host_irq),
    .stat_int     (stat_int_q),
    .en_mask      (en_mask),
    .edge_mask    (edge_mask),
    .tmo_flags    (tmo_q)
);

// File: tb/irq_carrier_regs_test.sv
module irq_carrier_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_offs = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  slot_irq_n = 8'hFF;
    logic [3:0]  slot_timeout = '0;
    logic [7:0]  slot_ack;
    logic        host_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_carrier_regs uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_offs     (bus_offs),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .slot_irq_n   (slot_irq_n),
        .slot_timeout (slot_timeout),
        .slot_ack     (slot_ack),
        .host_irq     (host_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int offs, input int data);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_offs = 4'(offs); bus_wdata = 16'(data);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int offs, output int data);
        bus_valid = 1'b1; bus_write = 1'b0; bus_offs = 4'(offs);
        @(negedge clk);
        data = int'(bus_rdata);
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and R2 empty map
        chk("R1 host_irq", host_irq, 0);
        chk("R1 slot_ack", slot_ack, 0);
        for (int o = 0; o < 16; o++) begin
            rd(o, v);
            chk("R1 reg after reset", v, 0);
        end
        step();
        chk("R2 rdata idle zero", bus_rdata, 0);

        // R2/R3 control readback, revision and reset word inert
        for (int s = 0; s < 4; s++) wr(s + 1, (37 * s + 'h5A) & 'hFF | 'hAB00);
        wr(0, 'hFFFF);
        wr(5, 'hFFFF);
        for (int s = 0; s < 4; s++) begin
            rd(s + 1, v);
            chk("R2 control readback", v, (37 * s + 'h5A) & 'hFF);
        end
        rd(0, v); chk("R2 revision zero", v, 0);
        rd(5, v); chk("R2 reset word zero", v, 0);
        rd(6, v); chk("R3 status with lines idle", v, 0);
        chk("R3 host idle", host_irq, 0);
        for (int s = 0; s < 4; s++) wr(s + 1, 0);

        // R4/R6/R7 sweep of every line over enable and edge settings
        for (int i = 0; i < 8; i++) begin
            for (int mode = 0; mode < 4; mode++) begin
                int en = mode & 1;
                int ed = (mode >> 1) & 1;
                int s = i / 2;
                int n = i % 2;
                wr(s + 1, (en << (6 + n)) | (ed << (4 + n)));
                slot_irq_n[i] = 1'b0;
                step();
                chk("R6 R7 host on assert", host_irq, en);
                step();
                chk("R6 R7 host one cycle later", host_irq, en & (1 - ed));
                rd(6, v);
                chk("R4 status follows line", v, en << i);
                slot_irq_n[i] = 1'b1;
                step();
                chk("R6 no pulse on release", host_irq, 0);
                rd(6, v);
                chk("R4 status after release", v, 0);
                wr(s + 1, 0);
            end
        end

        // R5 disabled line keeps its status
        wr(1, 'h40);
        slot_irq_n[0] = 1'b0;
        step();
        chk("R5 setup host", host_irq, 1);
        wr(1, 'h00);
        slot_irq_n[0] = 1'b1;
        step();
        slot_irq_n[0] = 1'b0; step();
        slot_irq_n[0] = 1'b1; step();
        rd(6, v);
        chk("R5 status frozen", v, 1);
        chk("R5 host held", host_irq, 1);
        wr(1, 'h40);
        step();
        rd(6, v);
        chk("R5 status released on enable", v, 0);
        chk("R5 host low", host_irq, 0);

        // R6 enabling an already asserted edge line gives one pulse
        slot_irq_n[1] = 1'b0;
        wr(1, 'h00);
        step();
        chk("R6 disabled no pulse", host_irq, 0);
        wr(1, 'hA0);
        step();
        chk("R6 pulse on enable", host_irq, 1);
        step();
        chk("R6 pulse ends", host_irq, 0);
        slot_irq_n[1] = 1'b1;
        step();
        wr(1, 0);

        // R7 mixed slot: edge line status does not hold host high
        wr(2, 'hD0);
        slot_irq_n[2] = 1'b0; slot_irq_n[3] = 1'b0;
        step();
        chk("R7 mixed host", host_irq, 1);
        step();
        chk("R7 level keeps host", host_irq, 1);
        slot_irq_n[3] = 1'b1;
        step();
        chk("R7 host low with edge bit set", host_irq, 0);
        rd(6, v);
        chk("R7 edge status remains", v, 'h4);

        // R9 acknowledge does not clear a held status bit
        wr(6, 'h4);
        chk("R9 ack strobe", slot_ack, 'h4);
        rd(6, v);
        chk("R9 status unchanged by ack", v, 'h4);
        slot_irq_n[2] = 1'b1;
        step();
        wr(2, 0);

        // R9 acknowledge strobes, one per line
        for (int i = 0; i < 8; i++) begin
            wr(6, 1 << i);
            chk("R9 ack bit", slot_ack, 1 << i);
            step();
            chk("R9 ack one cycle", slot_ack, 0);
        end

        // R8 timeout flags
        for (int m = 0; m < 4; m++) begin
            slot_timeout[m] = 1'b1; step(); slot_timeout[m] = 1'b0;
            rd(6, v);
            chk("R8 timeout set", v, 1 << (12 + m));
            slot_timeout[m] = 1'b1;
            wr(6, 1 << (12 + m));
            slot_timeout[m] = 1'b0;
            rd(6, v);
            chk("R8 set beats clear", v, 1 << (12 + m));
            wr(6, 1 << (12 + m));
            rd(6, v);
            chk("R8 write one clears", v, 0);
        end
        slot_timeout = 4'hF; step(); slot_timeout = 4'h0;
        wr(6, 1 << 13);
        rd(6, v);
        chk("R8 selective clear", v, 'hD000);
        chk("R8 host untouched", host_irq, 0);

        // R10 error flags
        wr(6, 'h0F00);
        rd(6, v);
        chk("R10 error write no effect", v, 'hD000);
        wr(6, 'hF000);
        rd(6, v);
        chk("R10 all clear", v, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule